// File: doc/BRIEF.md
# Scan-Shadowed Pipeline Register

This block is a parallel pipeline register with a diagnostic shadow register beside it. In normal operation the pipeline register captures a data bus on its own clock and presents the value on an output bus with an active-low enable. The shadow register runs on a separate diagnostic clock. It can act as a shift register in a system-wide scan loop. It can also take a snapshot of the pipeline register, or drive its own contents back out through the data port, for example to write a word into an external control-store RAM.

One mode input serves both registers. On the pipeline side it chooses between the data bus and the shadow register. On the diagnostic side it works together with the serial input to choose between shifting, capturing and driving. Both bidirectional buses are split into value and enable signals, so the block fits in a core that has no tri-state pads. Several instances chain into one scan loop by connecting each serial output to the next serial input. While mode is high, the serial input passes straight through every stage, so all stages in the chain see the same command bit.

Top module: `scan_pipe_reg`

## Requirements
- R1: A pipeline-clock edge taken with `pipe_rst` high clears the pipeline register. A diagnostic-clock edge taken with `diag_rst` high clears the shadow register and deasserts `bus_oe`.
- R2: On a pipeline-clock rising edge with `mode_sel` low, the pipeline register loads `bus_in`.
- R3: On a pipeline-clock rising edge with `mode_sel` high, the pipeline register loads the shadow register value that was present before that edge.
- R4: On a diagnostic-clock rising edge with `mode_sel` low, the shadow register shifts toward its most significant bit. `scan_in` enters bit 0 and bit i moves to bit i+1. `bus_oe` is deasserted.
- R5: `scan_out` is combinational. It equals shadow bit W-1 while `mode_sel` is low and equals `scan_in` while `mode_sel` is high.
- R6: On a diagnostic-clock edge with `mode_sel` high and `scan_in` low, the shadow register loads the pipeline register value, whatever the state of `q_oe_n`.
- R7: A diagnostic-clock edge with `mode_sel` high and `scan_in` high asserts `bus_oe` and leaves the shadow register unchanged. A later diagnostic edge under any other combination deasserts `bus_oe`. `bus_out` always carries the shadow register value.
- R8: `q_out` always carries the pipeline register value, and `q_oe` is the inverse of `q_oe_n`.
- R9: Edges of both clocks at the same instant each use the other register's pre-edge value. With `mode_sel` high and `scan_in` low, the two registers therefore exchange contents. With `mode_sel` low, a load and a shift happen together.
- R10: Two instances chained output-to-input form a 2W-bit scan path. After 2W shift edges, the first bit shifted in sits in the most significant bit of the downstream instance.
- R11: Each register changes only on its own clock. A pipeline edge alone leaves the shadow register and `bus_oe` unchanged, and a diagnostic edge alone leaves the pipeline register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pipe_clk | input | 1 | Pipeline register clock |
| pipe_rst | input | 1 | Synchronous reset for the pipeline register, active high |
| diag_clk | input | 1 | Diagnostic (shadow) register clock |
| diag_rst | input | 1 | Synchronous reset for the shadow register and drive enable, active high |
| mode_sel | input | 1 | Source select for both registers |
| scan_in | input | 1 | Serial input and second diagnostic command bit |
| scan_out | output | 1 | Serial output |
| bus_in | input | W | Data port, incoming value |
| bus_out | output | W | Data port, value driven when enabled (shadow register) |
| bus_oe | output | 1 | Data port drive enable |
| q_oe_n | input | 1 | Output bus enable, active low |
| q_out | output | W | Output bus value (pipeline register) |
| q_oe | output | 1 | Output bus drive enable |

## Verification
The bench focuses on edges where both clocks fire together. A design that lets either register see the other's new value would copy one value into both registers instead of swapping them, or would shift in a just-loaded bit. It checks that the serial output switches to the serial input as soon as mode rises, with no clock edge. A registered or wrongly muxed path there breaks command broadcast down a chain, which the two-instance 16-bit scan test exposes through the downstream shadow contents. It also checks that the drive enable drops on the first non-drive diagnostic edge, and that a drive edge keeps the shadow value. A design that cleared or reloaded the shadow register on that edge would write a corrupted word to the control store.

// File: rtl/scan_pipe_pkg.sv
package scan_pipe_pkg;

    // Diagnostic register operation selected by mode and serial input.
    typedef enum logic [1:0] {
        DOP_SHIFT   = 2'd0,
        DOP_CAPTURE = 2'd1,
        DOP_DRIVE   = 2'd2
    } diag_op_e;

    function automatic diag_op_e decode_diag_op(input logic mode, input logic ser);
        diag_op_e op;
        if (!mode) begin
            op = DOP_SHIFT;
        end else if (!ser) begin
            op = DOP_CAPTURE;
        end else begin
            op = DOP_DRIVE;
        end
        return op;
    endfunction

endpackage

// File: rtl/scan_pipe_decode.sv
module scan_pipe_decode
    import scan_pipe_pkg::*;
(
    input  logic     mode_sel,
    input  logic     scan_in,
    input  logic     shadow_msb,
    output diag_op_e op,
    output logic     scan_out
);

    always_comb begin
        op       = decode_diag_op(mode_sel, scan_in);
        scan_out = mode_sel ? scan_in : shadow_msb;
    end

endmodule

// File: rtl/scan_pipe_pipeline.sv
module scan_pipe_pipeline #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_sel,
    input  logic [W-1:0] data_in,
    input  logic [W-1:0] shadow_in,
    output logic [W-1:0] pipe_q
);

    typedef struct packed {
        logic [W-1:0] value;
    } pipe_state_t;

    pipe_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.value = mode_sel ? shadow_in : data_in;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pipe_q = st_q.value;

endmodule

// File: rtl/scan_pipe_shadow.sv
module scan_pipe_shadow
    import scan_pipe_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  diag_op_e     op,
    input  logic         scan_in,
    input  logic [W-1:0] y_in,
    output logic [W-1:0] shadow_q,
    output logic         drive_q
);

    typedef struct packed {
        logic [W-1:0] shadow;
        logic         drive;
    } diag_state_t;

    diag_state_t  st_d, st_q;
    logic [W-1:0] shifted;

    for (genvar i = 0; i < W; i++) begin : g_shift
        if (i == 0) begin : g_entry
            assign shifted[i] = scan_in;
        end else begin : g_link
            assign shifted[i] = st_q.shadow[i-1];
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (op)
            DOP_SHIFT: begin
                st_d.shadow = shifted;
                st_d.drive  = 1'b0;
            end
            DOP_CAPTURE: begin
                st_d.shadow = y_in;
                st_d.drive  = 1'b0;
            end
            DOP_DRIVE: begin
                st_d.drive  = 1'b1;
            end
            default: begin
                st_d.drive  = 1'b0;
            end
        endcase
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign shadow_q = st_q.shadow;
    assign drive_q  = st_q.drive;

endmodule

// File: rtl/scan_pipe_reg.sv
module scan_pipe_reg
    import scan_pipe_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         pipe_clk,
    input  logic         pipe_rst,
    input  logic         diag_clk,
    input  logic         diag_rst,
    input  logic         mode_sel,
    input  logic         scan_in,
    output logic         scan_out,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out,
    output logic         bus_oe,
    input  logic         q_oe_n,
    output logic [W-1:0] q_out,
    output logic         q_oe
);

    localparam int MSB = W - 1;

    diag_op_e     op;
    logic [W-1:0] pipe_val;
    logic [W-1:0] shadow_val;
    logic         drive_val;

    scan_pipe_decode u_decode (
        .mode_sel   (mode_sel),
        .scan_in    (scan_in),
        .shadow_msb (shadow_val[MSB]),
        .op         (op),
        .scan_out   (scan_out)
    );

    scan_pipe_pipeline #(.W(W)) u_pipe (
        .clk       (pipe_clk),
        .rst       (pipe_rst),
        .mode_sel  (mode_sel),
        .data_in   (bus_in),
        .shadow_in (shadow_val),
        .pipe_q    (pipe_val)
    );

    scan_pipe_shadow #(.W(W)) u_shadow (
        .clk      (diag_clk),
        .rst      (diag_rst),
        .op       (op),
        .scan_in  (scan_in),
        .y_in     (pipe_val),
        .shadow_q (shadow_val),
        .drive_q  (drive_val)
    );

    assign q_out   = pipe_val;
    assign q_oe    = ~q_oe_n;
    assign bus_out = shadow_val;
    assign bus_oe  = drive_val;

endmodule

// File: rtl/scan_pipe_reg_chk.sv
module scan_pipe_reg_chk #(
    parameter int W = 8
) (
    input logic         pipe_clk,
    input logic         pipe_rst,
    input logic         diag_clk,
    input logic         diag_rst,
    input logic         mode_sel,
    input logic         scan_in,
    input logic         scan_out,
    input logic [W-1:0] bus_in,
    input logic [W-1:0] bus_out,
    input logic         bus_oe,
    input logic         q_oe_n,
    input logic [W-1:0] q_out,
    input logic         q_oe
);

    p_pipe_reset_r1: assert property (@(posedge pipe_clk)
        pipe_rst |=> (q_out == '0));

    p_diag_reset_r1: assert property (@(posedge diag_clk)
        diag_rst |=> (!bus_oe && bus_out == '0));

    p_pipe_load_r2: assert property (@(posedge pipe_clk) disable iff (pipe_rst)
        !mode_sel |=> (q_out == $past(bus_in)));

    p_pipe_from_shadow_r3: assert property (@(posedge pipe_clk) disable iff (pipe_rst)
        mode_sel |=> (q_out == $past(bus_out)));

    p_shift_r4: assert property (@(posedge diag_clk) disable iff (diag_rst)
        !mode_sel |=> (!bus_oe && bus_out[0] == $past(scan_in)
                       && bus_out[W-1:1] == $past(bus_out[W-2:0])));

    p_so_msb_r5: assert property (@(posedge diag_clk) disable iff (diag_rst)
        !mode_sel |-> (scan_out == bus_out[W-1]));

    p_so_pass_r5: assert property (@(posedge diag_clk) disable iff (diag_rst)
        mode_sel |-> (scan_out == scan_in));

    p_capture_r6: assert property (@(posedge diag_clk) disable iff (diag_rst)
        (mode_sel && !scan_in) |=> (!bus_oe && bus_out == $past(q_out)));

    p_drive_r7: assert property (@(posedge diag_clk) disable iff (diag_rst)
        (mode_sel && scan_in) |=> (bus_oe && $stable(bus_out)));

    p_out_enable_r8: assert property (@(posedge pipe_clk)
        q_oe != q_oe_n);

endmodule

bind scan_pipe_reg scan_pipe_reg_chk #(.W(W)) u_chk (
    .pipe_clk (pipe_clk),
    .pipe_rst (pipe_rst),
    .diag_clk (diag_clk),
    .diag_rst (diag_rst),
    .mode_sel (mode_sel),
    .scan_in  (scan_in),
    .scan_out (scan_out),
    .bus_in   (bus_in),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe),
    .q_oe_n   (q_oe_n),
    .q_out    (q_out),
    .q_oe     (q_oe)
);

// File: tb/test_scan_pipe_reg.sv
module test_scan_pipe_reg;

    localparam int W = 8;

    typedef struct {
        string    req;
        int       sel;
        logic [7:0] exp;
    } item_t;

    logic clk = 1'b0;
    logic p_en = 1'b0, d_en = 1'b0;
    logic pipe_clk, diag_clk;
    logic pipe_rst = 1'b1, diag_rst = 1'b1;
    logic mode_sel = 1'b0, scan_in = 1'b0, q_oe_n = 1'b1;
    logic [W-1:0] bus_in = '0;
    logic scan_out, bus_oe, q_oe;
    logic [W-1:0] bus_out, q_out;
    logic t_scan_out, t_bus_oe, t_q_oe;
    logic [W-1:0] t_bus_out, t_q_out;

    int compared = 0, mismatched = 0;
    bit done = 0;
    item_t sb[$];

    // model state
    logic [7:0] m_p = 0, m_s = 0, t_p = 0, t_s = 0;
    logic m_d = 0, t_d = 0;

    always #4 clk = ~clk;
    assign pipe_clk = clk & p_en;
    assign diag_clk = clk & d_en;

    scan_pipe_reg #(.W(W)) i_scan_pipe_reg (
        .pipe_clk(pipe_clk), .pipe_rst(pipe_rst), .diag_clk(diag_clk), .diag_rst(diag_rst),
        .mode_sel(mode_sel), .scan_in(scan_in), .scan_out(scan_out),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .q_oe_n(q_oe_n), .q_out(q_out), .q_oe(q_oe)
    );

    scan_pipe_reg #(.W(W)) i_scan_pipe_reg_tail (
        .pipe_clk(pipe_clk), .pipe_rst(pipe_rst), .diag_clk(diag_clk), .diag_rst(diag_rst),
        .mode_sel(mode_sel), .scan_in(scan_out), .scan_out(t_scan_out),
        .bus_in(8'h00), .bus_out(t_bus_out), .bus_oe(t_bus_oe),
        .q_oe_n(q_oe_n), .q_out(t_q_out), .q_oe(t_q_oe)
    );

    function automatic logic [7:0] actual(int sel);
        case (sel)
            0: return q_out;
            1: return {7'd0, q_oe};
            2: return bus_out;
            3: return {7'd0, bus_oe};
            4: return {7'd0, scan_out};
            5: return t_bus_out;
            6: return {7'd0, t_scan_out};
            default: return t_q_out;
        endcase
    endfunction

    // monitor: compares queued expectations once outputs have settled
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                compared++;
                if (actual(it.sel) !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, actual(it.sel), it.exp);
                end
            end
        end
    end

    task automatic push(string req, int sel, logic [7:0] e);
        item_t it;
        it.req = req; it.sel = sel; it.exp = e;
        sb.push_back(it);
    endtask

    task automatic push_all(string req);
        push(req, 0, m_p);
        push(req, 1, {7'd0, ~q_oe_n});
        push(req, 2, m_s);
        push(req, 3, {7'd0, m_d});
        push(req, 4, {7'd0, mode_sel ? scan_in : m_s[7]});
        push(req, 5, t_s);
        push(req, 7, t_p);
    endtask

    // driver: one clocking step, model updated from the requirements
    task automatic step(string req, bit pe, bit de, bit pr, bit dr,
                        bit md, bit si, logic [7:0] din, bit oen);
        logic [7:0] np, ns, ntp, nts;
        logic nd, ntd, so;
        np = m_p; ns = m_s; nd = m_d; ntp = t_p; nts = t_s; ntd = t_d;
        so = md ? si : m_s[7];
        if (pe) begin
            np  = pr ? 8'h00 : (md ? m_s : din);
            ntp = pr ? 8'h00 : (md ? t_s : 8'h00);
        end
        if (de) begin
            if (dr) begin
                ns = 0; nd = 0; nts = 0; ntd = 0;
            end else if (!md) begin
                ns = {m_s[6:0], si}; nd = 0;
                nts = {t_s[6:0], so}; ntd = 0;
            end else if (!si) begin
                ns = m_p; nd = 0; nts = t_p; ntd = 0;
            end else begin
                nd = 1; ntd = 1;
            end
        end
        pipe_rst = pr; diag_rst = dr; mode_sel = md; scan_in = si;
        bus_in = din; q_oe_n = oen; p_en = pe; d_en = de;
        @(posedge clk);
        @(negedge clk);
        p_en = 0; d_en = 0; pipe_rst = 0; diag_rst = 0;
        m_p = np; m_s = ns; m_d = nd; t_p = ntp; t_s = nts; t_d = ntd;
        push_all(req);
        #2;
    endtask

    // combinational look without any clock edge
    task automatic peek(string req, bit md, bit si);
        mode_sel = md; scan_in = si;
        @(negedge clk);
        push(req, 4, {7'd0, md ? si : m_s[7]});
        push(req, 6, {7'd0, md ? si : t_s[7]});
        #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [15:0] pat;
        @(negedge clk);
        #2;
        // R1: reset both domains
        step("R1", 1, 1, 1, 1, 0, 0, 8'hFF, 1);
        // R2, R11: pipeline loads, shadow untouched
        step("R2_R11", 1, 0, 0, 0, 0, 1, 8'h5A, 0);
        step("R2", 1, 0, 0, 0, 0, 0, 8'hC3, 0);
        step("R2", 1, 0, 0, 0, 0, 0, 8'h00, 0);
        step("R2", 1, 0, 0, 0, 0, 0, 8'hFF, 0);
        // R4, R5, R11: shift 0xA5 MSB first, pipeline holds
        for (int i = 7; i >= 0; i--) begin
            step("R4_R5_R11", 0, 1, 0, 0, 0, ((8'hA5 >> i) & 1) != 0, 8'h11, 0);
        end
        // R5: pass-through with mode high, no edge
        peek("R5", 1, 0);
        peek("R5", 1, 1);
        peek("R5", 0, 1);
        // R3: pipeline takes shadow value
        step("R3", 1, 0, 0, 0, 1, 0, 8'h77, 0);
        // R6: capture with outputs disabled
        step("R2", 1, 0, 0, 0, 0, 0, 8'h3C, 1);
        step("R6", 0, 1, 0, 0, 1, 0, 8'h00, 1);
        step("R8", 0, 0, 0, 0, 0, 0, 8'h00, 0);
        // R7: drive edge keeps shadow, later edge drops enable
        step("R7", 0, 1, 0, 0, 1, 1, 8'h00, 0);
        step("R7", 0, 1, 0, 0, 1, 1, 8'h00, 0);
        step("R11", 1, 0, 0, 0, 0, 0, 8'h12, 0);
        step("R7", 0, 1, 0, 0, 0, 1, 8'h00, 0);
        // R9: swap at a shared edge
        for (int i = 7; i >= 0; i--) begin
            step("R4", 0, 1, 0, 0, 0, ((8'h34 >> i) & 1) != 0, 8'h00, 0);
        end
        step("R9", 1, 1, 0, 0, 1, 0, 8'h99, 0);
        // R9: load and shift together
        step("R9", 1, 1, 0, 0, 0, 1, 8'hE1, 0);
        // R8: output enable follows its input
        step("R8", 0, 0, 0, 0, 0, 0, 8'h00, 1);
        step("R8", 0, 0, 0, 0, 0, 0, 8'h00, 0);
        // R1: diag reset only while driving, pipeline kept
        step("R7", 0, 1, 0, 0, 1, 1, 8'h00, 0);
        step("R1", 0, 1, 0, 1, 0, 0, 8'h00, 0);
        // R10: 16-bit scan through two instances
        pat = 16'hC3A5;
        for (int i = 15; i >= 0; i--) begin
            step("R10", 0, 1, 0, 0, 0, pat[i], 8'h00, 0);
        end
        peek("R10", 0, 0);
        done = 1;
        @(negedge clk);
        #2;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule